// File: doc/BRIEF.md
# EUI-64 Identity Record Generator and Checker

This block builds and verifies the 15-byte identity record that sits at the bottom of a write-protected memory page. The record holds a length code, a fixed project identifier and a 64-bit EUI node address, and it ends with an inverted CRC16. Multi-byte fields are stored least significant byte first. The node address is formed from a fixed 24-bit company identifier placed above a 40-bit extension identifier supplied by the user.

The generator half takes an extension identifier and a start pulse. It then streams the finished record out, one byte per enabled cycle, with each byte's address, and computes the CRC as it goes. The checker half accepts a byte stream read back from memory and confirms the fixed fields. It recomputes the CRC over the body and compares it with the stored inverted value, then reports a single pass flag. The two halves are independent and can run in the same cycles, for example with the generator's stream looped straight into the checker.

Top module: `nodeid_rec`

## Requirements
- R1: While reset is held and on the first cycle after it, gen_vld, gen_done, chk_done and chk_pass are all 0.
- R2: The generated record places 0Ch at address 0. Addresses 1 to 4 carry the project code 28h 11h 00h 00h. Addresses 5 to 9 carry the extension identifier, least significant byte first. Addresses 10 to 12 carry the company code 35h 60h 00h.
- R3: Addresses 13 and 14 carry the bitwise inverse of a CRC16 taken over addresses 0 to 12, low byte at 13. The CRC uses the reflected polynomial x16+x15+x2+1 (A001h), starts at 0000h and takes each byte least significant bit first. For extension 234567ABCDh the record is 0C 28 11 00 00 CD AB 67 45 23 35 60 00 FF 3E.
- R4: A gen_start cycle loads gen_ext and emits nothing. After that, every cycle with gen_en high produces the next byte on gen_vld/gen_addr/gen_data one cycle later, with addresses counting up from 0. A cycle with gen_en low gives gen_vld low on the next cycle and does not advance the address.
- R5: gen_done is high only together with the byte at address 14. After that byte the generator stays idle and ignores gen_en until the next gen_start.
- R6: A gen_start while a record is still being emitted abandons it. The next emitted byte is address 0 of the record for the newly loaded extension.
- R7: The checker takes a byte on each cycle with chk_vld high, in address order from 0 to 14. One cycle after byte 14 is accepted, chk_done pulses for one cycle, and chk_pass is 1 when the length, project, company and CRC bytes all match.
- R8: A wrong length byte, project byte, company byte or stored CRC byte makes that result fail (chk_pass 0). A wrong extension byte also fails, through the CRC. A failed record does not affect the result of the next record.
- R9: chk_pass keeps its value between results, and chk_done is never high on two cycles in a row.
- R10: Cycles with chk_vld low are ignored by the checker: they neither advance the byte position nor change the result.
- R11: The generator and checker operate independently in the same cycles. A generated record looped into the checker gives chk_done with chk_pass 1 on the cycle after gen_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_start | input | 1 | Load extension identifier and restart the generator |
| gen_en | input | 1 | Allow the generator to emit one byte this cycle |
| gen_ext | input | 40 | Extension identifier for the node address |
| gen_vld | output | 1 | Generated byte valid |
| gen_addr | output | 4 | Address of the generated byte |
| gen_data | output | 8 | Generated byte |
| gen_done | output | 1 | High with the last record byte |
| chk_vld | input | 1 | Byte to be checked is valid |
| chk_data | input | 8 | Byte to be checked |
| chk_done | output | 1 | One-cycle strobe: check result is ready |
| chk_pass | output | 1 | Result of the most recent check |

## Verification
The generator's emission and the checker's acceptance can fall in the same cycle. The case of interest is the generator's final byte, which carries gen_done, while the checker is still consuming the previous bytes of a stream. The bench provokes this by looping gen_vld and gen_data straight into the checker while gen_en is randomly stalled, so both halves advance together and hold together. The run is judged by requiring, on every byte, the expected address and data from a bench model of the record, and by requiring chk_done with chk_pass 1 exactly one cycle after gen_done.

// File: rtl/nodeid_pkg.sv
package nodeid_pkg;
  localparam int BYTE_W     = 8;
  localparam int EUI_W      = 64;
  localparam int EXT_W      = 40;
  localparam int COMP_W     = EUI_W - EXT_W;
  localparam int PROJ_W     = 32;
  localparam int CRC_W      = 16;
  localparam int LEN_BYTES  = 1;
  localparam int PROJ_BYTES = PROJ_W / BYTE_W;
  localparam int EXT_BYTES  = EXT_W / BYTE_W;
  localparam int HEAD_BYTES = LEN_BYTES + PROJ_BYTES;
  localparam int BODY_BYTES = HEAD_BYTES + EUI_W / BYTE_W;
  localparam int REC_BYTES  = BODY_BYTES + CRC_W / BYTE_W;
  localparam int IDX_W      = $clog2(REC_BYTES);
  localparam int BODY_W     = BODY_BYTES * BYTE_W;

  localparam logic [BYTE_W-1:0] LEN_DEF  = 8'h0C;
  localparam logic [PROJ_W-1:0] PROJ_DEF = 32'h0000_1128;
  localparam logic [COMP_W-1:0] COMP_DEF = 24'h00_6035;
  localparam logic [CRC_W-1:0]  POLY_DEF = 16'hA001;

  // Record body as a little-endian byte vector: byte k sits at bits 8k+7:8k.
  function automatic logic [BODY_W-1:0] make_body(
    input logic [EXT_W-1:0]  ext,
    input logic [BYTE_W-1:0] len,
    input logic [PROJ_W-1:0] proj,
    input logic [COMP_W-1:0] comp
  );
    return {comp, ext, proj, len};
  endfunction

  // Byte positions that must equal a constant in every record.
  function automatic logic is_fixed_pos(input int pos);
    return (pos < HEAD_BYTES) || ((pos >= HEAD_BYTES + EXT_BYTES) && (pos < BODY_BYTES));
  endfunction
endpackage

// File: rtl/nodeid_crc16.sv
module nodeid_crc16
  import nodeid_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = POLY_DEF
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_out
);
  logic [BYTE_W:0][CRC_W-1:0] stage;

  assign stage[0] = crc_in;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][0] ^ din[b];
    assign stage[b+1] = fb ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/nodeid_gen.sv
module nodeid_gen
  import nodeid_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LEN_CODE  = LEN_DEF,
  parameter logic [PROJ_W-1:0] PROJ_CODE = PROJ_DEF,
  parameter logic [COMP_W-1:0] COMP_CODE = COMP_DEF,
  parameter logic [CRC_W-1:0]  POLY      = POLY_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              en,
  input  logic [EXT_W-1:0]  ext,
  output logic              out_vld,
  output logic [IDX_W-1:0]  out_addr,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_done
);
  localparam int SLOTS = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);
  localparam logic [IDX_W-1:0] BODY_END = IDX_W'(BODY_BYTES);
  localparam logic [IDX_W-1:0] CRC_LO   = IDX_W'(BODY_BYTES);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [EXT_W-1:0]  ext_q;
  logic [CRC_W-1:0]  crc_q, crc_nx;
  logic [BODY_W-1:0] body;
  logic [BYTE_W-1:0] body_b [SLOTS];
  logic [BYTE_W-1:0] cur_byte;

  assign body = make_body(ext_q, LEN_CODE, PROJ_CODE, COMP_CODE);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < BODY_BYTES) begin : g_body
      assign body_b[g] = body[g*BYTE_W +: BYTE_W];
    end else begin : g_pad
      assign body_b[g] = '0;
    end
  end

  always_comb begin
    if (idx < BODY_END)       cur_byte = body_b[idx];
    else if (idx == CRC_LO)   cur_byte = ~crc_q[BYTE_W-1:0];
    else                      cur_byte = ~crc_q[CRC_W-1:BYTE_W];
  end

  nodeid_crc16 #(.POLY(POLY)) u_crc (
    .crc_in (crc_q),
    .din    (cur_byte),
    .crc_out(crc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      ext_q    <= '0;
      crc_q    <= '0;
      out_vld  <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
      out_done <= 1'b0;
    end else begin
      out_vld  <= 1'b0;
      out_done <= 1'b0;
      if (start) begin
        ext_q <= ext;
        idx   <= '0;
        crc_q <= '0;
        busy  <= 1'b1;
      end else if (busy && en) begin
        out_vld  <= 1'b1;
        out_addr <= idx;
        out_data <= cur_byte;
        out_done <= (idx == LAST_IDX);
        if (idx < BODY_END) crc_q <= crc_nx;
        if (idx == LAST_IDX) busy <= 1'b0;
        else                 idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nodeid_chk.sv
module nodeid_chk
  import nodeid_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LEN_CODE  = LEN_DEF,
  parameter logic [PROJ_W-1:0] PROJ_CODE = PROJ_DEF,
  parameter logic [COMP_W-1:0] COMP_CODE = COMP_DEF,
  parameter logic [CRC_W-1:0]  POLY      = POLY_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] in_data,
  output logic              res_done,
  output logic              res_pass
);
  localparam int SLOTS = 2 ** IDX_W;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(REC_BYTES - 1);
  localparam logic [IDX_W-1:0]  BODY_END = IDX_W'(BODY_BYTES);
  localparam logic [IDX_W-1:0]  CRC_LO   = IDX_W'(BODY_BYTES);
  localparam logic [BODY_W-1:0] REF_BODY = make_body('0, LEN_CODE, PROJ_CODE, COMP_CODE);

  logic [IDX_W-1:0]  idx;
  logic [CRC_W-1:0]  crc_q, crc_nx;
  logic              bad;
  logic              byte_ok;
  logic [BYTE_W-1:0] ref_b   [SLOTS];
  logic              fixed_m [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_ref
    if (g < BODY_BYTES && is_fixed_pos(g)) begin : g_fix
      assign ref_b[g]   = REF_BODY[g*BYTE_W +: BYTE_W];
      assign fixed_m[g] = 1'b1;
    end else begin : g_free
      assign ref_b[g]   = '0;
      assign fixed_m[g] = 1'b0;
    end
  end

  always_comb begin
    if (idx < BODY_END)     byte_ok = !fixed_m[idx] || (in_data == ref_b[idx]);
    else if (idx == CRC_LO) byte_ok = (in_data == ~crc_q[BYTE_W-1:0]);
    else                    byte_ok = (in_data == ~crc_q[CRC_W-1:BYTE_W]);
  end

  nodeid_crc16 #(.POLY(POLY)) u_crc (
    .crc_in (crc_q),
    .din    (in_data),
    .crc_out(crc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      crc_q    <= '0;
      bad      <= 1'b0;
      res_done <= 1'b0;
      res_pass <= 1'b0;
    end else begin
      res_done <= 1'b0;
      if (in_vld) begin
        if (idx == LAST_IDX) begin
          res_done <= 1'b1;
          res_pass <= !bad && byte_ok;
          idx      <= '0;
          crc_q    <= '0;
          bad      <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          bad <= bad || !byte_ok;
          if (idx < BODY_END) crc_q <= crc_nx;
        end
      end
    end
  end
endmodule

// File: rtl/nodeid_rec.sv
module nodeid_rec
  import nodeid_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LEN_CODE  = LEN_DEF,
  parameter logic [PROJ_W-1:0] PROJ_CODE = PROJ_DEF,
  parameter logic [COMP_W-1:0] COMP_CODE = COMP_DEF,
  parameter logic [CRC_W-1:0]  POLY      = POLY_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_start,
  input  logic              gen_en,
  input  logic [EXT_W-1:0]  gen_ext,
  output logic              gen_vld,
  output logic [IDX_W-1:0]  gen_addr,
  output logic [BYTE_W-1:0] gen_data,
  output logic              gen_done,
  input  logic              chk_vld,
  input  logic [BYTE_W-1:0] chk_data,
  output logic              chk_done,
  output logic              chk_pass
);
  nodeid_gen #(
    .LEN_CODE(LEN_CODE), .PROJ_CODE(PROJ_CODE), .COMP_CODE(COMP_CODE), .POLY(POLY)
  ) u_gen (
    .clk     (clk),
    .rst     (rst),
    .start   (gen_start),
    .en      (gen_en),
    .ext     (gen_ext),
    .out_vld (gen_vld),
    .out_addr(gen_addr),
    .out_data(gen_data),
    .out_done(gen_done)
  );

  nodeid_chk #(
    .LEN_CODE(LEN_CODE), .PROJ_CODE(PROJ_CODE), .COMP_CODE(COMP_CODE), .POLY(POLY)
  ) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (chk_vld),
    .in_data (chk_data),
    .res_done(chk_done),
    .res_pass(chk_pass)
  );
endmodule

// File: rtl/nodeid_rec_props.sv
module nodeid_rec_props
  import nodeid_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LEN_CODE = LEN_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic              gen_en,
  input logic              gen_vld,
  input logic [IDX_W-1:0]  gen_addr,
  input logic [BYTE_W-1:0] gen_data,
  input logic              gen_done,
  input logic              chk_vld,
  input logic              chk_done,
  input logic              chk_pass
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!gen_vld && !gen_done && !chk_done && !chk_pass));

  a_r2_len_first: assert property (@(posedge clk) disable iff (rst)
    (gen_vld && gen_addr == '0) |-> gen_data == LEN_CODE);

  a_r4_idle_no_emit: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> !gen_vld);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (gen_vld && $past(gen_vld) && gen_addr != '0) |-> gen_addr == $past(gen_addr) + 1'b1);

  a_r5_done_last: assert property (@(posedge clk) disable iff (rst)
    gen_done |-> (gen_vld && gen_addr == LAST_IDX));

  a_r7_done_after_byte: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> $past(chk_vld));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    chk_done |=> !chk_done);

  a_r9_pass_hold: assert property (@(posedge clk) disable iff (rst)
    !chk_done |-> $stable(chk_pass));
endmodule

bind nodeid_rec nodeid_rec_props #(.LEN_CODE(LEN_CODE)) u_props (
  .clk     (clk),
  .rst     (rst),
  .gen_en  (gen_en),
  .gen_vld (gen_vld),
  .gen_addr(gen_addr),
  .gen_data(gen_data),
  .gen_done(gen_done),
  .chk_vld (chk_vld),
  .chk_done(chk_done),
  .chk_pass(chk_pass)
);

// File: tb/test_nodeid_rec.sv
`timescale 1ns/1ps
module test_nodeid_rec;
  typedef logic [7:0] rec_t [15];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_start = 1'b0;
  logic        gen_en = 1'b0;
  logic [39:0] gen_ext = '0;
  logic        gen_vld, gen_done;
  logic [3:0]  gen_addr;
  logic [7:0]  gen_data;
  logic        chk_vld, chk_done, chk_pass;
  logic [7:0]  chk_data;
  logic        loop_on = 1'b0;
  logic        drv_vld = 1'b0;
  logic [7:0]  drv_data = '0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    chk_vld  = loop_on ? gen_vld  : drv_vld;
    chk_data = loop_on ? gen_data : drv_data;
  end

  nodeid_rec i_nodeid_rec (
    .clk(clk), .rst(rst),
    .gen_start(gen_start), .gen_en(gen_en), .gen_ext(gen_ext),
    .gen_vld(gen_vld), .gen_addr(gen_addr), .gen_data(gen_data), .gen_done(gen_done),
    .chk_vld(chk_vld), .chk_data(chk_data), .chk_done(chk_done), .chk_pass(chk_pass)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bit-serial reference CRC over the 13 body bytes.
  function automatic logic [15:0] crc_ref(input rec_t r);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < 13; i++)
      for (int b = 0; b < 8; b++) begin
        logic x = c[0] ^ r[i][b];
        c = {1'b0, c[15:1]};
        if (x) c = c ^ 16'hA001;
      end
    return c;
  endfunction

  function automatic rec_t build_rec(input logic [39:0] ext);
    rec_t r;
    logic [15:0] c;
    r[0] = 8'h0C; r[1] = 8'h28; r[2] = 8'h11; r[3] = 8'h00; r[4] = 8'h00;
    for (int k = 0; k < 5; k++) r[5+k] = ext[8*k +: 8];
    r[10] = 8'h35; r[11] = 8'h60; r[12] = 8'h00;
    r[13] = 8'h00; r[14] = 8'h00;
    c = crc_ref(r);
    r[13] = ~c[7:0];
    r[14] = ~c[15:8];
    return r;
  endfunction

  // Start the generator and follow `limit` emitted bytes (R4/R5 timing).
  task automatic run_gen(input logic [39:0] ext, input rec_t exp, input int stall_pct,
                         input int limit, input string req);
    int idx = 0;
    bit prev_en;
    @(negedge clk);
    gen_start = 1'b1; gen_ext = ext; gen_en = 1'b1;
    @(negedge clk);
    gen_start = 1'b0;
    check(!gen_vld, "R4", "no byte on start cycle", gen_vld, 0);
    while (idx < limit) begin
      prev_en = (($urandom % 100) >= stall_pct);
      gen_en = prev_en;
      @(negedge clk);
      if (prev_en) begin
        check(gen_vld && gen_addr == idx, "R4", "address", gen_addr, idx);
        check(gen_data == exp[idx], (idx >= 13) ? "R3" : "R2", "data", gen_data, exp[idx]);
        check(gen_done == (idx == 14), "R5", "done flag", gen_done, idx == 14);
        if (loop_on && idx < 14)
          check(!chk_done, "R11", "early check result", chk_done, 0);
        idx++;
      end else begin
        check(!gen_vld, "R4", "stall gives no byte", gen_vld, 0);
      end
    end
    if (limit == 15) begin
      gen_en = 1'b1;
      @(negedge clk);
      check(!gen_vld, "R5", "idle after last byte", gen_vld, 0);
      if (loop_on) begin
        check(chk_done, "R11", "check result after gen_done", chk_done, 1);
        check(chk_pass, "R11", "looped record passes", chk_pass, 1);
      end
      gen_en = 1'b0;
    end
  endtask

  // Feed a record to the checker with random gaps (R7/R10) and judge it.
  task automatic send_rec(input rec_t r, input int gap_pct, input bit exp_pass, input string req);
    for (int i = 0; i < 15; i++) begin
      while (($urandom % 100) < gap_pct) begin
        drv_vld = 1'b0;
        @(negedge clk);
        check(!chk_done, "R10", "gap gives no result", chk_done, 0);
      end
      drv_vld = 1'b1; drv_data = r[i];
      @(negedge clk);
      if (i < 14) check(!chk_done, "R7", "no early result", chk_done, 0);
    end
    drv_vld = 1'b0;
    check(chk_done, "R7", "result strobe", chk_done, 1);
    check(chk_pass == exp_pass, req, "pass flag", chk_pass, exp_pass);
    @(negedge clk);
    check(!chk_done, "R9", "strobe one cycle", chk_done, 0);
    check(chk_pass == exp_pass, "R9", "pass held", chk_pass, exp_pass);
  endtask

  initial begin
    rec_t ex_lit = '{8'h0C, 8'h28, 8'h11, 8'h00, 8'h00, 8'hCD, 8'hAB, 8'h67,
                     8'h45, 8'h23, 8'h35, 8'h60, 8'h00, 8'hFF, 8'h3E};
    rec_t r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!gen_vld && !gen_done && !chk_done && !chk_pass, "R1", "outputs in reset",
          {gen_vld, gen_done, chk_done, chk_pass}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!gen_vld && !gen_done && !chk_done && !chk_pass, "R1", "outputs after reset",
          {gen_vld, gen_done, chk_done, chk_pass}, 0);

    // R2 R3: directed known record, no stalls.
    run_gen(40'h23_4567_ABCD, ex_lit, 0, 15, "R3");
    // R7: the same known record passes the checker.
    send_rec(ex_lit, 0, 1'b1, "R7");

    // R6: restart in the middle of a record.
    run_gen(40'h11_2233_4455, build_rec(40'h11_2233_4455), 0, 6, "R6");
    run_gen(40'hFF_FFFF_FFFF, build_rec(40'hFF_FFFF_FFFF), 30, 15, "R6");

    // R8: corrupted fields each fail, and a good record passes afterwards.
    r = ex_lit; r[0]  = 8'h0D; send_rec(r, 20, 1'b0, "R8");
    r = ex_lit; r[2]  = 8'h10; send_rec(r, 20, 1'b0, "R8");
    r = ex_lit; r[11] = 8'h61; send_rec(r, 20, 1'b0, "R8");
    r = ex_lit; r[14] = 8'hFE; send_rec(r, 20, 1'b0, "R8");
    r = ex_lit; r[7]  = 8'h66; send_rec(r, 20, 1'b0, "R8");
    send_rec(ex_lit, 40, 1'b1, "R8");

    // R10: random records with heavy gaps, some corrupted.
    for (int n = 0; n < 12; n++) begin
      logic [39:0] e = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      rec_t rr = build_rec(e);
      bit bad = ($urandom % 2) == 1;
      if (bad) rr[$urandom % 15] ^= 8'(1 + ($urandom % 255));
      send_rec(rr, 50, !bad, "R10");
    end

    // R11: generator looped into the checker, random stalls, corner extensions too.
    loop_on = 1'b1;
    run_gen(40'h00_0000_0000, build_rec(40'h0), 0, 15, "R11");
    run_gen(40'hFF_FFFF_FFFF, build_rec(40'hFF_FFFF_FFFF), 50, 15, "R11");
    for (int n = 0; n < 20; n++) begin
      logic [39:0] e = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      run_gen(e, build_rec(e), $urandom % 60, 15, "R11");
    end
    loop_on = 1'b0;

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule